// File: doc/BRIEF.md
# Synthesizer Divider Word Serializer

This block takes a channel number and turns it into the write sequence for a frequency synthesizer. The synthesizer has a write-only three-line port: serial data, serial clock and latch enable. Each channel has a reference divider count, a main feedback count and a swallow count. These are held in a small read-only table in compressed form. On each request the block reads the entry, restores the full counts, and builds one 21-bit register word for the reference divider and one for the feedback divider.

Each word is shifted out most significant bit first. Latch enable stays low while the bits move and is raised afterwards to commit the word. When the request asks for it, a function word goes out before the two divider words. That word sets what drives the synthesizer's lock pin: the lock detector, the reference divider output, or the feedback divider output.

A single-cycle `start` begins a transfer. `busy` covers the whole transfer, and `done` marks its end. The serial rate comes from the one-cycle `tick` enable: every serial clock half-period uses one tick.

Top module: `synth_word_serializer`

## Requirements
- R1: After reset and whenever no transfer is in progress, `syn_clk` and `syn_le` are high and `busy` and `done` are low.
- R2: Each word is exactly 21 bits, sent MSB first. A bit is placed on `syn_data` in the same cycle that `syn_clk` falls, and it is taken at the next rising edge of `syn_clk`. `syn_data` never changes while `syn_clk` is high.
- R3: `syn_le` is low for every rising edge of `syn_clk` within a word. It rises one tick after the 21st rising clock edge. It stays high for at least two tick periods before it falls for the next word.
- R4: The reference word is, from MSB to LSB: 1, then two 0s, then eight 0s, then the 8-bit reference count, then the address 00. In bit terms this is (1<<20) | (reference<<2).
- R5: The feedback word is, from MSB to LSB: six 0s, then the 8-bit main count, then two 0s, then the 3-bit swallow count, then the address 01. In bit terms this is (main<<7) | (swallow<<2) | 1.
- R6: A transfer with `with_func`=1 sends the function word, then the reference word, then the feedback word. With `with_func`=0 it sends only the reference word and then the feedback word. Each word is committed by its own rise of latch enable.
- R7: The function word is (field<<2) | 3, with three leading 0s. The field depends on `mode`: 0x2104 for `mode`=0 (lock detect on the pin), 0x2110 for `mode`=1 (reference divider on the pin), 0x0108 for `mode`=2 (feedback divider on the pin), and 0x2104 for `mode`=3.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the final rise of `syn_le`. `busy` is high from the cycle after an accepted `start` until `done` is asserted.
- R9: A `start` that arrives while `busy` is high is ignored. The channel and mode of the running transfer are kept, and no further transfer follows it.
- R10: A `start` that arrives in the cycle where `done` is high is accepted as a new transfer.
- R11: The channel table, given as (reference, main, swallow), holds: ch0 (173,190,7), ch1 (163,180,1), ch2 (164,181,3), ch3 (165,182,5), ch4 (175,193,7), ch5 (158,175,2), ch6 (157,174,2), ch7 (180,199,7). Internally each entry is stored as reference−150, main−170 and swallow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Serial-rate enable, one pulse per half serial clock |
| start | input | 1 | Transfer request, honoured only when idle |
| with_func | input | 1 | Send the function word ahead of the divider words |
| chan | input | 3 | Channel index |
| mode | input | 2 | Lock-pin routing selection for the function word |
| syn_data | output | 1 | Serial data to the synthesizer |
| syn_clk | output | 1 | Serial clock, idles high |
| syn_le | output | 1 | Latch enable, low while shifting |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two events can fall in the same cycle: the end-of-transfer pulse and a fresh request. While that happens, the serial engine is still holding latch enable high after the last word. The bench chains every transfer of its sweep over channels, modes and function-word selection. Each new `start` is raised in the very cycle where `done` is seen, so the request overlaps the hold of the previous latch. The bench then judges that the new transfer's words are correct and that latch enable stayed high for at least two tick periods. A separate request sent in the middle of a transfer checks that busy-time starts are dropped.

// File: rtl/synth_ser_pkg.sv
package synth_ser_pkg;

  localparam int WORD_W   = 21;
  localparam int REF_OFS  = 150;
  localparam int MAIN_OFS = 170;

  typedef enum logic [1:0] {
    WSEL_FUNC = 2'd0,
    WSEL_REF  = 2'd1,
    WSEL_FB   = 2'd2
  } wsel_e;

  typedef struct packed {
    logic [7:0] ref_c;   // reference count minus REF_OFS
    logic [2:0] swal;    // swallow count
    logic [4:0] main_c;  // main count minus MAIN_OFS
  } chan_ent_t;

  function automatic chan_ent_t pack_entry(input int r, input int m, input int s);
    chan_ent_t e;
    e.ref_c  = 8'(r - REF_OFS);
    e.swal   = 3'(s);
    e.main_c = 5'(m - MAIN_OFS);
    return e;
  endfunction

  function automatic chan_ent_t chan_table(input logic [2:0] idx);
    chan_ent_t e;
    case (idx)
      3'd0:    e = pack_entry(173, 190, 7);
      3'd1:    e = pack_entry(163, 180, 1);
      3'd2:    e = pack_entry(164, 181, 3);
      3'd3:    e = pack_entry(165, 182, 5);
      3'd4:    e = pack_entry(175, 193, 7);
      3'd5:    e = pack_entry(158, 175, 2);
      3'd6:    e = pack_entry(157, 174, 2);
      default: e = pack_entry(180, 199, 7);
    endcase
    return e;
  endfunction

endpackage

// File: rtl/synth_chan_rom.sv
module synth_chan_rom
  import synth_ser_pkg::*;
#(
  parameter int NCHAN = 8,
  localparam int CH_W = $clog2(NCHAN)
)(
  input  logic             clk,
  input  logic             rd_en,
  input  logic [CH_W-1:0]  addr,
  output chan_ent_t        rdata
);

  chan_ent_t mem [NCHAN];

  for (genvar i = 0; i < NCHAN; i++) begin : g_ent
    assign mem[i] = chan_table(3'(i % 8));
  end

  // registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/synth_word_pack.sv
module synth_word_pack
  import synth_ser_pkg::*;
#(
  parameter logic [15:0] FIELD_NORM  = 16'h2104,
  parameter logic [15:0] FIELD_RTEST = 16'h2110,
  parameter logic [15:0] FIELD_FBPIN = 16'h0108
)(
  input  chan_ent_t          ent,
  input  logic [1:0]         mode,
  input  wsel_e              wsel,
  output logic [WORD_W-1:0]  word
);

  logic [7:0]  ref_full;
  logic [7:0]  main_full;
  logic [15:0] fn_field;

  always_comb begin
    ref_full  = ent.ref_c + 8'(REF_OFS);
    main_full = {3'b000, ent.main_c} + 8'(MAIN_OFS);
    case (mode)
      2'd1:    fn_field = FIELD_RTEST;
      2'd2:    fn_field = FIELD_FBPIN;
      default: fn_field = FIELD_NORM;
    endcase
    case (wsel)
      WSEL_FUNC: word = {3'b000, fn_field, 2'b11};
      WSEL_REF:  word = {1'b1, 2'b00, 8'h00, ref_full, 2'b00};
      default:   word = {6'b000000, main_full, 2'b00, ent.swal, 2'b01};
    endcase
  end

endmodule

// File: rtl/synth_shift_engine.sv
module synth_shift_engine #(
  parameter int WORD_W = 21,
  localparam int CNT_W = $clog2(WORD_W)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic              sdata,
  output logic              sclk,
  output logic              sle,
  output logic              ready,
  output logic              latched
);

  typedef enum logic [2:0] {E_IDLE, E_LOW, E_HIGH, E_LATCH, E_HOLD} est_e;

  est_e              st;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  assign ready = (st == E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      sdata   <= 1'b0;
      sclk    <= 1'b1;
      sle     <= 1'b1;
      latched <= 1'b0;
    end else begin
      latched <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            shreg <= word;
            cnt   <= '0;
            st    <= E_LOW;
          end
        end
        E_LOW: begin
          if (tick) begin
            sclk  <= 1'b0;
            sle   <= 1'b0;
            sdata <= shreg[WORD_W-1];
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            st    <= E_HIGH;
          end
        end
        E_HIGH: begin
          if (tick) begin
            sclk <= 1'b1;
            if (cnt == CNT_W'(WORD_W - 1)) begin
              cnt <= '0;
              st  <= E_LATCH;
            end else begin
              cnt <= cnt + 1'b1;
              st  <= E_LOW;
            end
          end
        end
        E_LATCH: begin
          if (tick) begin
            sle     <= 1'b1;
            latched <= 1'b1;
            st      <= E_HOLD;
          end
        end
        default: begin
          if (tick) st <= E_IDLE;
        end
      endcase
    end
  end

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> !sclk); // R2
  AST_RISE_UNDER_LOW_LE: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !sle); // R3
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == E_IDLE) |-> (sclk && sle)); // R1
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(WORD_W)); // R2

endmodule

// File: rtl/synth_word_serializer.sv
module synth_word_serializer
  import synth_ser_pkg::*;
#(
  parameter int NCHAN = 8,
  localparam int CH_W = $clog2(NCHAN)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic            with_func,
  input  logic [CH_W-1:0] chan,
  input  logic [1:0]      mode,
  output logic            syn_data,
  output logic            syn_clk,
  output logic            syn_le,
  output logic            busy,
  output logic            done
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} sst_e;

  sst_e              st;
  wsel_e             wsel;
  logic [CH_W-1:0]   ch_q;
  logic [1:0]        mode_q;
  logic              accept;
  chan_ent_t         ent;
  logic [WORD_W-1:0] word;
  logic              eng_go;
  logic              eng_ready;
  logic              eng_latched;

  assign accept = (st == S_IDLE) && start;
  assign eng_go = (st == S_ISSUE) && eng_ready;

  synth_chan_rom #(.NCHAN(NCHAN)) u_rom (
    .clk   (clk),
    .rd_en (accept),
    .addr  (chan),
    .rdata (ent)
  );

  synth_word_pack u_pack (
    .ent  (ent),
    .mode (mode_q),
    .wsel (wsel),
    .word (word)
  );

  synth_shift_engine #(.WORD_W(WORD_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .go      (eng_go),
    .word    (word),
    .sdata   (syn_data),
    .sclk    (syn_clk),
    .sle     (syn_le),
    .ready   (eng_ready),
    .latched (eng_latched)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      wsel   <= WSEL_REF;
      ch_q   <= '0;
      mode_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            ch_q   <= chan;
            mode_q <= mode;
            wsel   <= with_func ? WSEL_FUNC : WSEL_REF;
            busy   <= 1'b1;
            st     <= S_FETCH;
          end
        end
        S_FETCH: st <= S_ISSUE;
        S_ISSUE: begin
          if (eng_ready) st <= S_WAIT;
        end
        default: begin
          if (eng_latched) begin
            if (wsel == WSEL_FB) begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= S_IDLE;
            end else begin
              wsel <= (wsel == WSEL_FUNC) ? WSEL_REF : WSEL_FB;
              st   <= S_ISSUE;
            end
          end
        end
      endcase
    end
  end

  AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(eng_latched)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ch_q) && $stable(mode_q))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (syn_le || !eng_ready) ); // R1

endmodule

// File: tb/synth_word_serializer_bench.sv
module synth_word_serializer_bench;

  localparam int TDIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic       with_func = 1'b0;
  logic [2:0] chan = '0;
  logic [1:0] mode = '0;
  logic       syn_data, syn_clk, syn_le, busy, done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tcnt = 0;

  synth_word_serializer u_synth_word_serializer (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .with_func(with_func),
    .chan(chan), .mode(mode), .syn_data(syn_data), .syn_clk(syn_clk),
    .syn_le(syn_le), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV - 1);
  end

  int ref_t  [8] = '{173, 163, 164, 165, 175, 158, 157, 180};
  int main_t [8] = '{190, 180, 181, 182, 193, 175, 174, 199};
  int swal_t [8] = '{7, 1, 3, 5, 7, 2, 2, 7};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial line monitor
  logic [20:0] log_w [256];
  int          log_n [256];
  int          log_c [256];
  int          nlog = 0;
  logic [20:0] acc = '0;
  int          nb = 0;
  logic        psclk = 1'b1, psle = 1'b1, psdata = 1'b0;
  int          rise_cyc = -1000;

  always @(negedge clk) begin
    if (!rst) begin
      if (psle && !syn_le) begin
        acc = '0; nb = 0;
        chk((cyc - rise_cyc) >= 2 * TDIV, "R3 latch hold", cyc - rise_cyc, 2 * TDIV);
      end
      if (psclk && syn_clk && (syn_data !== psdata))
        chk(1'b0, "R2 data moved with clock high", syn_data, psdata);
      if (!psclk && syn_clk) begin
        if (syn_le) chk(1'b0, "R3 clock rise with latch high", syn_le, 0);
        acc = {acc[19:0], syn_data};
        nb++;
      end
      if (!psle && syn_le) begin
        if (nlog < 256) begin
          log_w[nlog] = acc; log_n[nlog] = nb; log_c[nlog] = cyc;
        end
        nlog++;
        rise_cyc = cyc;
      end
    end
    psclk = syn_clk; psle = syn_le; psdata = syn_data;
  end

  function automatic logic [20:0] exp_word(input int kind, input int ch, input int md);
    int field;
    if (kind == 0) begin
      field = (md == 1) ? 'h2110 : (md == 2) ? 'h0108 : 'h2104;
      return 21'((field << 2) | 3);
    end else if (kind == 1) return 21'((1 << 20) | (ref_t[ch] << 2));
    else return 21'((main_t[ch] << 7) | (swal_t[ch] << 2) | 1);
  endfunction

  // start is raised at the current negedge; returns at the negedge done is seen
  task automatic run_one(input int ch, input int md, input bit wf, input bit poke);
    int base, nexp, w;
    base = nlog;
    chan = 3'(ch); mode = 2'(md); with_func = wf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    chk(done === 1'b0, "R8 done single cycle", done, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chan = 3'((ch + 3) % 8); mode = 2'((md + 1) % 4); with_func = ~wf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 5000, "R8 transfer timeout", w, 0);
    nexp = wf ? 3 : 2;
    chk((nlog - base) == nexp, "R6 word count", nlog - base, nexp);
    if ((nlog - base) == nexp) begin
      for (int k = 0; k < nexp; k++) begin
        int kind;
        kind = wf ? k : k + 1;
        chk(log_n[base + k] == 21, "R2 bits per word", log_n[base + k], 21);
        chk(log_w[base + k] == exp_word(kind, ch, md),
            kind == 0 ? "R7 function word" : kind == 1 ? "R4 R11 reference word" : "R5 R11 feedback word",
            log_w[base + k], exp_word(kind, ch, md));
      end
      chk(cyc == log_c[nlog - 1] + 1, "R8 done timing", cyc, log_c[nlog - 1] + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(syn_clk === 1'b1, "R1 clock idle", syn_clk, 1);
    chk(syn_le === 1'b1, "R1 latch idle", syn_le, 1);
    chk(busy === 1'b0, "R1 busy idle", busy, 0);
    chk(done === 1'b0, "R1 done idle", done, 0);
    // back-to-back sweep: each start raised in the cycle done is high (R10)
    for (int wf = 0; wf < 2; wf++)
      for (int md = 0; md < 4; md++)
        for (int ch = 0; ch < 8; ch++)
          run_one(ch, md, wf[0], 1'b0);
    // R9: start during busy is dropped
    @(negedge clk);
    repeat (10) @(negedge clk);
    run_one(5, 2, 1'b1, 1'b1);
    begin
      int n0;
      n0 = nlog;
      repeat (300) @(negedge clk);
      chk(busy === 1'b0, "R9 no queued transfer busy", busy, 0);
      chk(nlog == n0, "R9 no queued transfer words", nlog, n0);
      chk(syn_clk === 1'b1 && syn_le === 1'b1, "R1 lines idle after transfer", {syn_clk, syn_le}, 3);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule